// File: doc/BRIEF.md
# Oversampled Slot-Multiplexed Packet Transmitter

This block is the sending half of a link that shares one optical fiber between both directions by taking turns. A fixed sampling tick oversamples the main data line, which may run at any rate up to 19.2 kbit/s. Because each data bit lasts about 52 µs and ticks come every 2.5 µs, one bit covers about 20 samples. The newest 31 samples sit in a history window. The window is reduced to a 9-bit word. The word holds the level at the far, oldest end of the window, where the first edge falls counting from that end, the slow control channel's level (up to 1200 bit/s), a flag asking the far end to loop back, and a parity bit.

A frame lasts 64 ticks. The first half is the sending slot and the second half is the listening slot. At the tick that opens each frame the current word is captured. It is then sent one bit per tick: a marker bit, the nine word bits most significant first, and a closing bit. The line then stays low until the next frame. A slot flag tells the optical front end when to emit and when to detect.

Top module: `tdm_packet_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the history is cleared to all zeros, the sampled control and loopback levels are cleared to 0, the frame position parks at 63 (last listening tick), and `ser_out` and `tx_active` are 0. The first tick after reset therefore opens a frame whose word is all zeros.
- R2: Only a clock edge with `sample_tick` high takes in `data_in`, `ctrl_in` and `loop_req`. Values these inputs hold between ticks have no effect on any later output.
- R3: The frame position advances by one per tick and wraps from 63 to 0. `tx_active` is 1 for positions 0 to 31 and 0 for positions 32 to 63.
- R4: Word bit 8 is the oldest of the 31 samples in the window.
- R5: Number the window samples 0 (oldest) to 30 (newest). Word bits 7:3 hold the smallest k in 1..30 for which sample k differs from sample k-1, or 0 when all 31 samples are equal.
- R6: Word bit 2 is the last sampled `ctrl_in` and word bit 1 is the last sampled `loop_req`.
- R7: Word bit 0 makes the number of ones in word bits 8:0 even.
- R8: The word is captured at the tick that moves the position from 63 to 0. It reflects the 31 ticks before that tick, and it stays fixed for the whole frame.
- R9: After the tick that sets position p, `ser_out` is 1 for p = 0, word bit (9 - p) for p = 1 to 9, 0 for p = 10, and 0 for p = 11 to 63. It changes only on ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle sampling enable, every 2.5 µs |
| data_in | input | 1 | Main data line, oversampled |
| ctrl_in | input | 1 | Slow control channel line |
| loop_req | input | 1 | Request for far-end loopback |
| ser_out | output | 1 | Serial line toward the emitter |
| tx_active | output | 1 | High during the sending slot |

## Verification
If the history window is wrong or shifts off a tick, the next frame shows a bad edge index or a bad oldest-level bit. This shows up 1 to 9 ticks after that frame opens, so within about 64 ticks of the fault. If the frame position is wrong, `tx_active` or the start bit shifts at the very next tick. A wrong latch moment or a packet register that changes mid-frame shows up as a bad bit in the same sending slot. Data driven between ticks is always the opposite of the ticked value, so sampling on a non-tick cycle gives a wrong word one frame later.

// File: rtl/tdm_tx_pkg.sv
// Package: default geometry of the slot-multiplexed transmitter.
// Assumes: the history is shorter than 2**IDX_W and the packet fits in
// the sending slot; modules take these as parameter defaults.
package tdm_tx_pkg;
    localparam int HIST_LEN    = 31;
    localparam int FRAME_TICKS = 64;
    localparam int TX_TICKS    = 32;
    localparam int IDX_W       = $clog2(HIST_LEN);
    localparam int CODE_W      = IDX_W + 4;
    localparam int PKT_W       = CODE_W + 2;
    localparam int POS_W       = $clog2(FRAME_TICKS);
endpackage

// File: rtl/tdm_hist_reg.sv
// Sample window: on every tick, shifts data_in into a HIST_LEN-deep history
// (bit 0 newest) and registers the control and loopback levels.
// Assumes: tick is a single-cycle enable; reset is synchronous, active low.
module tdm_hist_reg #(
    parameter int HIST_LEN = tdm_tx_pkg::HIST_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                data_in,
    input  logic                ctrl_in,
    input  logic                loop_in,
    output logic [HIST_LEN-1:0] hist,
    output logic                ctrl_s,
    output logic                loop_s
);
    // Purpose: take one sample of every input per tick, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            ctrl_s <= 1'b0;
            loop_s <= 1'b0;
        end else if (tick) begin
            hist   <= {hist[HIST_LEN-2:0], data_in};
            ctrl_s <= ctrl_in;
            loop_s <= loop_in;
        end
    end

    AST_HIST_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (hist[0] == $past(data_in)) && (ctrl_s == $past(ctrl_in))); // R2
    AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $past(rst_n)) |=> $stable(hist)); // R2
endmodule

// File: rtl/tdm_edge_encoder.sv
// Window encoder (combinational): reduces the sample window to a word of
// {oldest level, first-edge index, control, loopback, even parity}.
// Assumes: hist[HIST_LEN-1] is the oldest sample; index k counts from it.
module tdm_edge_encoder #(
    parameter int HIST_LEN = tdm_tx_pkg::HIST_LEN,
    parameter int IDX_W    = $clog2(HIST_LEN),
    parameter int CODE_W   = IDX_W + 4
) (
    input  logic [HIST_LEN-1:0] hist,
    input  logic                ctrl_s,
    input  logic                loop_s,
    output logic [CODE_W-1:0]   code
);
    logic [IDX_W-1:0]  edge_idx;
    logic [CODE_W-2:0] body;
    logic              found;

    // Purpose: find the first level change, scanning from the oldest sample.
    always_comb begin
        edge_idx = '0;
        found    = 1'b0;
        for (int k = 1; k < HIST_LEN; k++) begin
            if (!found && (hist[HIST_LEN-k] != hist[HIST_LEN-1-k])) begin
                edge_idx = IDX_W'(k);
                found    = 1'b1;
            end
        end
    end

    // Purpose: pack the fields and append the even-parity bit.
    always_comb begin
        body = {hist[HIST_LEN-1], edge_idx, ctrl_s, loop_s};
        code = {body, ^body};
    end
endmodule

// File: rtl/tdm_slot_timer.sv
// Slot timer: counts ticks around a FRAME_TICKS frame. Positions below
// TX_TICKS form the sending slot. It flags the tick that opens a frame.
// Assumes: reset parks the count at the last listening position, so the
// first tick after reset opens a frame.
module tdm_slot_timer #(
    parameter int FRAME_TICKS = tdm_tx_pkg::FRAME_TICKS,
    parameter int TX_TICKS    = tdm_tx_pkg::TX_TICKS,
    parameter int POS_W       = $clog2(FRAME_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic frame_start,
    output logic tx_active
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_TICKS - 1);

    logic [POS_W-1:0] pos;

    // Purpose: advance the frame position once per tick, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= LAST_POS;
        else if (tick)
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end

    // Purpose: decode the frame-opening tick and the sending slot.
    always_comb begin
        frame_start = tick && (pos == LAST_POS);
        tx_active   = rst_n && (pos < POS_W'(TX_TICKS));
    end

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(rst_n)) |=> pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1)); // R3
    AST_SLOT_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> (pos == '0)); // R3
endmodule

// File: rtl/tdm_serializer.sv
// Packet serializer: loads {start 1, word, stop 0} at frame start and
// shifts it out MSB first, one bit per tick; zeros follow.
// Assumes: the packet is no longer than the sending slot.
module tdm_serializer #(
    parameter int CODE_W = tdm_tx_pkg::CODE_W,
    parameter int PKT_W  = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              ser_out
);
    logic [PKT_W-1:0] shreg;

    // Purpose: capture the framed packet or shift it by one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= {1'b1, code, 1'b0};
        else if (tick)
            shreg <= {shreg[PKT_W-2:0], 1'b0};
    end

    assign ser_out = shreg[PKT_W-1];

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ser_out); // R9
    AST_PACKET_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(shreg[PKT_W-2:1]) % 2 == 0)); // R7
    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $past(rst_n)) |=> $stable(ser_out)); // R9
endmodule

// File: rtl/tdm_packet_tx.sv
// Top: oversampled, slot-multiplexed packet transmitter. Samples the data,
// control and loopback inputs per tick, encodes the window, and sends one
// packet per frame during the sending slot.
// Assumes: sample_tick is a one-cycle pulse; reset is synchronous, active low.
module tdm_packet_tx #(
    parameter int HIST_LEN    = tdm_tx_pkg::HIST_LEN,
    parameter int FRAME_TICKS = tdm_tx_pkg::FRAME_TICKS,
    parameter int TX_TICKS    = tdm_tx_pkg::TX_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_tick,
    input  logic data_in,
    input  logic ctrl_in,
    input  logic loop_req,
    output logic ser_out,
    output logic tx_active
);
    localparam int IDX_W  = $clog2(HIST_LEN);
    localparam int CODE_W = IDX_W + 4;
    localparam int PKT_W  = CODE_W + 2;

    logic [HIST_LEN-1:0] hist;
    logic                ctrl_s;
    logic                loop_s;
    logic [CODE_W-1:0]   code;
    logic                frame_start;

    tdm_hist_reg #(.HIST_LEN(HIST_LEN)) u_hist (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .data_in(data_in), .ctrl_in(ctrl_in), .loop_in(loop_req),
        .hist(hist), .ctrl_s(ctrl_s), .loop_s(loop_s)
    );

    tdm_edge_encoder #(.HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_enc (
        .hist(hist), .ctrl_s(ctrl_s), .loop_s(loop_s), .code(code)
    );

    tdm_slot_timer #(.FRAME_TICKS(FRAME_TICKS), .TX_TICKS(TX_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .frame_start(frame_start), .tx_active(tx_active)
    );

    tdm_serializer #(.CODE_W(CODE_W), .PKT_W(PKT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .load(frame_start), .code(code), .ser_out(ser_out)
    );

    AST_QUIET_WHEN_LISTENING: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !ser_out); // R9
    AST_RESET_LINE_LOW: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ser_out && !tx_active)); // R1
endmodule

// File: tb/tdm_packet_tx_tb.sv
// Directed bench: one task per scenario, with a reference model of the
// frame built from the requirements.
module tdm_packet_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_tick = 1'b0;
    logic data_in = 1'b0;
    logic ctrl_in = 1'b0;
    logic loop_req = 1'b0;
    logic ser_out;
    logic tx_active;

    int n_chk = 0;
    int n_bad = 0;

    logic [30:0] m_hist = '0;
    logic        m_ctrl = 1'b0;
    logic        m_loop = 1'b0;
    int          m_pos  = 63;
    logic [10:0] m_pkt  = '0;
    logic [8:0]  cap    = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_packet_tx dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .data_in(data_in), .ctrl_in(ctrl_in), .loop_req(loop_req),
        .ser_out(ser_out), .tx_active(tx_active)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Word from the requirements: R4 oldest, R5 first edge, R6 levels, R7 parity.
    function automatic logic [8:0] model_word();
        logic [4:0] idx = '0;
        logic [7:0] body;
        for (int k = 30; k >= 1; k--)
            if (m_hist[30-k] != m_hist[31-k]) idx = 5'(k);
        body = {m_hist[30], idx, m_ctrl, m_loop};
        return {body, ^body};
    endfunction

    // One tick with the given levels, then a non-tick cycle with the opposite levels (R2).
    task automatic do_tick(input logic d, input logic c, input logic l);
        logic exp_bit;
        @(negedge clk);
        data_in = d; ctrl_in = c; loop_req = l; sample_tick = 1'b1;
        if (m_pos == 63) m_pkt = {1'b1, model_word(), 1'b0}; // R8
        m_hist = {m_hist[29:0], d};
        m_ctrl = c; m_loop = l;
        m_pos  = (m_pos + 1) % 64;
        @(negedge clk);
        sample_tick = 1'b0;
        data_in = ~d; ctrl_in = ~c; loop_req = ~l;
        exp_bit = (m_pos < 11) ? m_pkt[10-m_pos] : 1'b0;
        check(ser_out === exp_bit, "R9 serial bit", 32'(ser_out), 32'(exp_bit));
        check(tx_active === (m_pos < 32), "R3 slot flag", 32'(tx_active), 32'(m_pos < 32));
        if (m_pos >= 1 && m_pos <= 9) cap[9-m_pos] = ser_out;
        @(negedge clk);
        check(ser_out === exp_bit, "R2 line held between ticks", 32'(ser_out), 32'(exp_bit));
    endtask

    // One full frame: window starts at tick 33; edges at sample k and k2 (k2 = 0: none).
    task automatic run_frame(input logic a, input int k, input int k2, input logic c, input logic l);
        for (int t = 0; t < 64; t++) begin
            logic d;
            d = a ^ (t >= 33 + k) ^ ((k2 > 0) && (t >= 33 + k2));
            do_tick(d, c, l);
        end
    endtask

    // Stimulus frame, then a neutral frame whose start sends it; compare to a hand value.
    task automatic scen_word(input logic a, input int k, input int k2, input logic c,
                             input logic l, input logic [8:0] exp, input string req);
        run_frame(a, k, k2, c, l);
        run_frame(1'b0, 31, 0, 1'b0, 1'b0);
        check(cap === exp, req, 32'(cap), 32'(exp));
    endtask

    task automatic scen_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ser_out === 1'b0, "R1 line low in reset", 32'(ser_out), 32'h0);
        check(tx_active === 1'b0, "R1 slot flag low in reset", 32'(tx_active), 32'h0);
        rst_n = 1'b1;
        m_hist = '0; m_ctrl = 1'b0; m_loop = 1'b0; m_pos = 63; m_pkt = '0;
        @(negedge clk);
        check(tx_active === 1'b0, "R1 parked at 63", 32'(tx_active), 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        scen_reset();
        // R1: the first frame after reset carries the all-zero word
        run_frame(1'b1, 31, 0, 1'b1, 1'b1);
        check(cap === 9'b0, "R1 first word after reset", 32'(cap), 32'h0);
        // R5 edge at sample 1, R6 control level
        scen_word(1'b0, 1, 0, 1'b1, 1'b0, 9'b0_00001_1_0_0, "R5 edge at index 1");
        // R5 edge at sample 30, R4 oldest high, R6 loopback
        scen_word(1'b1, 30, 0, 1'b0, 1'b1, 9'b1_11110_0_1_0, "R5 edge at index 30");
        // R5 no edge, R4 oldest high
        scen_word(1'b1, 31, 0, 1'b1, 1'b0, 9'b1_00000_1_0_0, "R4 steady high window");
        // R5 two edges: the first one wins; R7 parity 1
        scen_word(1'b0, 7, 12, 1'b0, 1'b0, 9'b0_00111_0_0_1, "R7 two edges parity");
        // R6 both flags set with steady low data
        scen_word(1'b0, 31, 0, 1'b1, 1'b1, 9'b0_00000_1_1_0, "R6 both flags");
        // R1 reset in mid-frame after a history of ones
        run_frame(1'b1, 31, 0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) do_tick(1'b1, 1'b1, 1'b1);
        scen_reset();
        run_frame(1'b0, 31, 0, 1'b0, 1'b0);
        check(cap === 9'b0, "R1 history cleared by reset", 32'(cap), 32'h0);
        // R8 toggling levels across two frames, checked tick by tick against the model
        run_frame(1'b1, 3, 20, 1'b0, 1'b1);
        run_frame(1'b0, 15, 0, 1'b1, 1'b0);
        run_frame(1'b0, 31, 0, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule